// File: doc/BRIEF.md
# Palette Lookup with Cursor Overlay

This block turns a raster stream of 8-bit palette indices into 24-bit RGB pixels for an indexed-colour display. Each incoming pixel carries its index together with its own x and y coordinate. The index selects one of 256 stored colours. A 64x64 hardware cursor can be laid over the picture. Each cursor pixel holds a 2-bit code: it either lets the palette colour through or replaces it with one of three colours set aside for the cursor.

A single write port loads the colour table, the three cursor colours, the 512-word cursor pattern, the packed cursor position and a two-flag control word. The control word can hide the cursor or force the whole picture to black. Results come out two cycles after the pixel enters, with the valid, line-end and frame-end markers delayed by the same amount.

Top module: `pal_cursor_overlay`

## Requirements
- R1: After reset, every colour entry, cursor colour, pattern word, the position and both control flags are zero. The outputs are low, and the first pixel presented comes out as 0x000000.
- R2: A pixel outside the cursor comes out as the colour stored at its index. A colour-table write (target 0, address = index, below 256) stores red in data bits 23:16, green in 15:8 and blue in 7:0.
- R3: out_valid, out_eol and out_eof repeat pix_valid, pix_valid&&pix_eol and pix_valid&&pix_eof exactly two cycles later, and consecutive pixels stream one per cycle. When out_valid is low, out_rgb is zero and both markers are low.
- R4: A register write to target 3, address 0 sets the cursor position, with x in data bits 23:12 and y in bits 11:0. A pixel is inside the cursor when ycur <= y < ycur+64 and xcur <= x < xcur+64, and the bounds are not reduced modulo 4096.
- R5: A pattern write (target 2, address 0..511) stores data bits 15:0 as one pattern word. Inside the cursor, with row = y-ycur and col = x-xcur, the pixel uses word row*8 + col/8 and the 2-bit code at bits (col mod 8)*2+1 : (col mod 8)*2.
- R6: Code 0 shows the palette colour. Codes 1, 2 and 3 show cursor colours 0, 1 and 2, which are written with target 1 at addresses 0 to 2 in the same RGB layout as the colour table.
- R7: While control bit 23 is set (target 3, address 1), no pixel shows a cursor colour.
- R8: While control bit 10 is set, every valid output pixel is 0x000000. This flag overrides the cursor.
- R9: A write changes the output of pixels presented from the cycle after the write is accepted. A pixel presented in the same cycle as the write still uses the old contents.
- R10: The following writes change nothing: target 1 at an address of 3 or more, target 0 at an address of 256 or more, and target 3 at an address other than 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_target | input | 2 | 0 colour table, 1 cursor colours, 2 pattern, 3 registers |
| cfg_addr | input | 9 | Entry or register address within the target |
| cfg_wdata | input | 24 | Write data |
| pix_valid | input | 1 | Input pixel present |
| pix_index | input | 8 | Palette index of the pixel |
| pix_x | input | 12 | Pixel column |
| pix_y | input | 12 | Pixel row |
| pix_eol | input | 1 | Last pixel of a line |
| pix_eof | input | 1 | Last pixel of a frame |
| out_valid | output | 1 | Output pixel present |
| out_rgb | output | 24 | Output colour, red in 23:16 |
| out_eol | output | 1 | Delayed line-end marker |
| out_eof | output | 1 | Delayed frame-end marker |

## Verification
A pixel presented before clock edge N has its colour and markers on the outputs after edge N+2. A configuration write accepted at edge N applies to pixels presented before edge N+1 or later. The bench drives inputs on falling edges. For an isolated pixel it reads the outputs on the second falling edge after it presents the pixel. In the streaming and write-timing tests it keeps presenting new inputs while it reads the result of the input two falling edges earlier, so every comparison falls in the cycle the pipeline depth gives.

// File: rtl/pco_pkg.sv
`timescale 1ns/1ps
package pco_pkg;
   typedef enum logic [1:0] {
      TGT_COLOR   = 2'd0,
      TGT_CURCOL  = 2'd1,
      TGT_PATTERN = 2'd2,
      TGT_REGS    = 2'd3
   } cfg_target_e;

   localparam int REG_POS  = 0;
   localparam int REG_CTRL = 1;
endpackage

// File: rtl/pco_regfile.sv
`timescale 1ns/1ps
module pco_regfile #(
   parameter int DEPTH = 256,
   parameter int WIDTH = 24,
   parameter int AW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

   if (DEPTH > (1 << AW)) begin : g_bad_aw
      $error("pco_regfile: AW too narrow for DEPTH");
   end

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && ({1'b0, waddr} < LIMIT)) begin
         mem[waddr] <= wdata;
      end
   end

   if (DEPTH == (1 << AW)) begin : g_full
      assign rdata = mem[raddr];
   end else begin : g_part
      assign rdata = ({1'b0, raddr} < LIMIT) ? mem[raddr] : '0;
   end
endmodule

// File: rtl/pco_cursor_window.sv
`timescale 1ns/1ps
module pco_cursor_window #(
   parameter int COORD_W        = 12,
   parameter int CUR_DIM        = 64,
   parameter int CODES_PER_WORD = 8,
   parameter int OFF_W          = $clog2(CUR_DIM),
   parameter int SEL_W          = $clog2(CODES_PER_WORD),
   parameter int PAT_AW         = 2*OFF_W - SEL_W
) (
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic [COORD_W-1:0] cur_x,
   input  logic [COORD_W-1:0] cur_y,
   input  logic               enable,
   output logic               hit,
   output logic [PAT_AW-1:0]  word_addr,
   output logic [SEL_W-1:0]   code_sel
);
   localparam logic [COORD_W:0] DIM_V = (COORD_W+1)'(CUR_DIM);

   if ((1 << OFF_W) != CUR_DIM) begin : g_bad_dim
      $error("pco_cursor_window: CUR_DIM must be a power of two");
   end
   if (CUR_DIM % CODES_PER_WORD != 0) begin : g_bad_row
      $error("pco_cursor_window: CUR_DIM must be a multiple of CODES_PER_WORD");
   end

   logic [COORD_W:0] dx, dy;
   logic [OFF_W-1:0] col, row;

   // Extra top bit: a pixel left of or above the cursor gives a large
   // unsigned difference and so fails the bound test.
   assign dx  = {1'b0, pix_x} - {1'b0, cur_x};
   assign dy  = {1'b0, pix_y} - {1'b0, cur_y};
   assign col = dx[OFF_W-1:0];
   assign row = dy[OFF_W-1:0];

   assign hit       = enable && (dx < DIM_V) && (dy < DIM_V);
   assign word_addr = {row, col[OFF_W-1:SEL_W]};
   assign code_sel  = col[SEL_W-1:0];
endmodule

// File: rtl/pal_cursor_overlay.sv
`timescale 1ns/1ps
module pal_cursor_overlay
   import pco_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int CH_W      = 8,
   parameter int COORD_W   = 12,
   parameter int CUR_DIM   = 64,
   parameter int CODE_W    = 2,
   parameter int WORD_W    = 16,
   parameter int CFG_AW    = 9,
   parameter int BLANK_BIT = 10,
   parameter int NOCUR_BIT = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_target,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [3*CH_W-1:0]    cfg_wdata,
   input  logic                 pix_valid,
   input  logic [IDX_W-1:0]     pix_index,
   input  logic [COORD_W-1:0]   pix_x,
   input  logic [COORD_W-1:0]   pix_y,
   input  logic                 pix_eol,
   input  logic                 pix_eof,
   output logic                 out_valid,
   output logic [3*CH_W-1:0]    out_rgb,
   output logic                 out_eol,
   output logic                 out_eof
);
   localparam int RGB_W          = 3*CH_W;
   localparam int POS_W          = 2*COORD_W;
   localparam int N_COLORS       = 1 << IDX_W;
   localparam int N_CURCOL       = (1 << CODE_W) - 1;
   localparam int CODES_PER_WORD = WORD_W / CODE_W;
   localparam int OFF_W          = $clog2(CUR_DIM);
   localparam int SEL_W          = $clog2(CODES_PER_WORD);
   localparam int PAT_DEPTH      = CUR_DIM * (CUR_DIM / CODES_PER_WORD);
   localparam int PAT_AW         = $clog2(PAT_DEPTH);

   localparam logic [CFG_AW:0] COLOR_LIM  = (CFG_AW+1)'(N_COLORS);
   localparam logic [CFG_AW:0] CURCOL_LIM = (CFG_AW+1)'(N_CURCOL);
   localparam logic [CFG_AW:0] PAT_LIM    = (CFG_AW+1)'(PAT_DEPTH);

   // elaboration-time parameter checks
   if (RGB_W < POS_W) begin : g_bad_pos
      $error("pal_cursor_overlay: write data too narrow for the position");
   end
   if (WORD_W > RGB_W || WORD_W % CODE_W != 0) begin : g_bad_word
      $error("pal_cursor_overlay: bad pattern word width");
   end
   if (NOCUR_BIT >= RGB_W || BLANK_BIT >= RGB_W || NOCUR_BIT == BLANK_BIT) begin : g_bad_ctrl
      $error("pal_cursor_overlay: control bit positions out of range");
   end
   if (CFG_AW < IDX_W || CFG_AW < PAT_AW) begin : g_bad_cfg_aw
      $error("pal_cursor_overlay: configuration address too narrow");
   end

   // ---------------- configuration decode ----------------
   cfg_target_e     tgt;
   logic [CFG_AW:0] addr_x;
   logic            we_color, we_curcol, we_pat, we_pos, we_ctrl;

   assign tgt       = cfg_target_e'(cfg_target);
   assign addr_x    = {1'b0, cfg_addr};
   assign we_color  = cfg_we && (tgt == TGT_COLOR)   && (addr_x < COLOR_LIM);
   assign we_curcol = cfg_we && (tgt == TGT_CURCOL)  && (addr_x < CURCOL_LIM);
   assign we_pat    = cfg_we && (tgt == TGT_PATTERN) && (addr_x < PAT_LIM);
   assign we_pos    = cfg_we && (tgt == TGT_REGS) && (cfg_addr == CFG_AW'(REG_POS));
   assign we_ctrl   = cfg_we && (tgt == TGT_REGS) && (cfg_addr == CFG_AW'(REG_CTRL));

   logic [POS_W-1:0] pos_q;
   logic             blank_q, nocur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         blank_q <= 1'b0;
         nocur_q <= 1'b0;
      end else begin
         if (we_pos) pos_q <= cfg_wdata[POS_W-1:0];
         if (we_ctrl) begin
            blank_q <= cfg_wdata[BLANK_BIT];
            nocur_q <= cfg_wdata[NOCUR_BIT];
         end
      end
   end

   // ---------------- storage ----------------
   logic [RGB_W-1:0]  pal_rd, cur_rd;
   logic [WORD_W-1:0] pat_rd;
   logic [PAT_AW-1:0] pat_raddr;
   logic [SEL_W-1:0]  code_sel;
   logic [CODE_W-1:0] code;
   logic              hit;

   pco_regfile #(.DEPTH(N_COLORS), .WIDTH(RGB_W), .AW(IDX_W)) u_color (
      .clk(clk), .rst_n(rst_n), .we(we_color),
      .waddr(cfg_addr[IDX_W-1:0]), .wdata(cfg_wdata),
      .raddr(pix_index), .rdata(pal_rd)
   );

   pco_regfile #(.DEPTH(N_CURCOL), .WIDTH(RGB_W), .AW(CODE_W)) u_curcol (
      .clk(clk), .rst_n(rst_n), .we(we_curcol),
      .waddr(cfg_addr[CODE_W-1:0]), .wdata(cfg_wdata),
      .raddr(code - CODE_W'(1)), .rdata(cur_rd)
   );

   pco_regfile #(.DEPTH(PAT_DEPTH), .WIDTH(WORD_W), .AW(PAT_AW)) u_pattern (
      .clk(clk), .rst_n(rst_n), .we(we_pat),
      .waddr(cfg_addr[PAT_AW-1:0]), .wdata(cfg_wdata[WORD_W-1:0]),
      .raddr(pat_raddr), .rdata(pat_rd)
   );

   pco_cursor_window #(
      .COORD_W(COORD_W), .CUR_DIM(CUR_DIM), .CODES_PER_WORD(CODES_PER_WORD),
      .OFF_W(OFF_W), .SEL_W(SEL_W), .PAT_AW(PAT_AW)
   ) u_window (
      .pix_x(pix_x), .pix_y(pix_y),
      .cur_x(pos_q[POS_W-1:COORD_W]), .cur_y(pos_q[COORD_W-1:0]),
      .enable(!nocur_q),
      .hit(hit), .word_addr(pat_raddr), .code_sel(code_sel)
   );

   assign code = pat_rd[code_sel*CODE_W +: CODE_W];

   // ---------------- stage 1: lookups ----------------
   logic             s1_valid, s1_eol, s1_eof, s1_blank, s1_cur_on;
   logic [RGB_W-1:0] s1_pal, s1_cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_eol    <= 1'b0;
         s1_eof    <= 1'b0;
         s1_blank  <= 1'b0;
         s1_cur_on <= 1'b0;
         s1_pal    <= '0;
         s1_cur    <= '0;
      end else begin
         s1_valid  <= pix_valid;
         s1_eol    <= pix_valid && pix_eol;
         s1_eof    <= pix_valid && pix_eof;
         s1_blank  <= blank_q;
         s1_cur_on <= hit && (code != '0);
         s1_pal    <= pal_rd;
         s1_cur    <= cur_rd;
      end
   end

   // ---------------- stage 2: select ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_eol   <= 1'b0;
         out_eof   <= 1'b0;
         out_rgb   <= '0;
      end else begin
         out_valid <= s1_valid;
         out_eol   <= s1_eol;
         out_eof   <= s1_eof;
         if (!s1_valid || s1_blank) out_rgb <= '0;
         else if (s1_cur_on)        out_rgb <= s1_cur;
         else                       out_rgb <= s1_pal;
      end
   end
endmodule

// File: rtl/pco_checker.sv
`timescale 1ns/1ps
module pco_checker #(
   parameter int RGB_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_valid,
   input logic             pix_eol,
   input logic             pix_eof,
   input logic             blank_q,
   input logic             out_valid,
   input logic             out_eol,
   input logic             out_eof,
   input logic [RGB_W-1:0] out_rgb
);
   assert_valid_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> ##2 out_valid);
   assert_idle_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> ##2 !out_valid);
   assert_eol_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_eol) |-> ##2 out_eol);
   assert_eof_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_eof) |-> ##2 out_eof);
   assert_quiet_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_rgb == '0 && !out_eol && !out_eof));
   assert_force_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && blank_q) |-> ##2 (out_rgb == '0));
endmodule

bind pal_cursor_overlay pco_checker #(.RGB_W(RGB_W)) u_pco_checker (
   .clk(clk), .rst_n(rst_n),
   .pix_valid(pix_valid), .pix_eol(pix_eol), .pix_eof(pix_eof),
   .blank_q(blank_q),
   .out_valid(out_valid), .out_eol(out_eol), .out_eof(out_eof),
   .out_rgb(out_rgb)
);

// File: tb/pal_cursor_overlay_test.sv
`timescale 1ns/1ps
module pal_cursor_overlay_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_target = '0;
   logic [8:0]  cfg_addr = '0;
   logic [23:0] cfg_wdata = '0;
   logic        pix_valid = 1'b0;
   logic [7:0]  pix_index = '0;
   logic [11:0] pix_x = '0;
   logic [11:0] pix_y = '0;
   logic        pix_eol = 1'b0;
   logic        pix_eof = 1'b0;
   logic        out_valid;
   logic [23:0] out_rgb;
   logic        out_eol;
   logic        out_eof;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   pal_cursor_overlay uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_target(cfg_target), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .pix_valid(pix_valid), .pix_index(pix_index), .pix_x(pix_x), .pix_y(pix_y),
      .pix_eol(pix_eol), .pix_eof(pix_eof),
      .out_valid(out_valid), .out_rgb(out_rgb), .out_eol(out_eol), .out_eof(out_eof)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] t, input logic [8:0] a, input logic [23:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_target = t; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic drive_pix(input logic [7:0] idx, input logic [11:0] x, input logic [11:0] y,
                            input logic eol, input logic eof);
      pix_valid = 1'b1; pix_index = idx; pix_x = x; pix_y = y; pix_eol = eol; pix_eof = eof;
   endtask

   task automatic idle_pix();
      pix_valid = 1'b0; pix_eol = 1'b0; pix_eof = 1'b0;
   endtask

   task automatic pixel_check(input string req, input logic [7:0] idx, input logic [11:0] x,
                              input logic [11:0] y, input logic [23:0] exp);
      @(negedge clk);
      drive_pix(idx, x, y, 1'b0, 1'b0);
      @(negedge clk);
      idle_pix();
      @(negedge clk);
      check({req, " valid"}, {31'd0, out_valid}, 32'd1);
      check(req, {8'd0, out_rgb}, {8'd0, exp});
   endtask

   task automatic t_reset();
      check("R1 reset valid", {31'd0, out_valid}, 32'd0);
      check("R1 reset rgb", {8'd0, out_rgb}, 32'd0);
      pixel_check("R1 zero tables", 8'h05, 12'd0, 12'd0, 24'h000000);
   endtask

   task automatic t_lookup();
      cfg_write(2'd0, 9'h012, 24'hA1B2C3);
      cfg_write(2'd0, 9'h0FF, 24'h010203);
      cfg_write(2'd0, 9'h000, 24'h7F0080);
      pixel_check("R2 index 12", 8'h12, 12'd500, 12'd300, 24'hA1B2C3);
      pixel_check("R2 index FF", 8'hFF, 12'd4095, 12'd4095, 24'h010203);
      pixel_check("R2 index 00", 8'h00, 12'd700, 12'd10, 24'h7F0080);
   endtask

   task automatic t_stream();
      @(negedge clk); drive_pix(8'h12, 12'd500, 12'd5, 1'b0, 1'b0);
      @(negedge clk); drive_pix(8'hFF, 12'd501, 12'd5, 1'b1, 1'b0);
      @(negedge clk); drive_pix(8'h00, 12'd502, 12'd5, 1'b1, 1'b1);
      check("R3 stream p0 rgb", {8'd0, out_rgb}, 32'hA1B2C3);
      check("R3 stream p0 eol", {30'd0, out_eol, out_eof}, 32'd0);
      @(negedge clk); idle_pix();
      check("R3 stream p1 rgb", {8'd0, out_rgb}, 32'h010203);
      check("R3 stream p1 eol", {30'd0, out_eol, out_eof}, 32'd2);
      @(negedge clk);
      check("R3 stream p2 rgb", {8'd0, out_rgb}, 32'h7F0080);
      check("R3 stream p2 eof", {30'd0, out_eol, out_eof}, 32'd3);
      @(negedge clk);
      check("R3 idle", {7'd0, out_valid, out_rgb}, 32'd0);
   endtask

   task automatic t_cursor();
      cfg_write(2'd3, 9'd0, {12'd100, 12'd50});
      cfg_write(2'd1, 9'd0, 24'h110000);
      cfg_write(2'd1, 9'd1, 24'h002200);
      cfg_write(2'd1, 9'd2, 24'h000033);
      cfg_write(2'd2, 9'd25, 24'h000800);   // row 3, col 13 -> code 2
      cfg_write(2'd2, 9'd511, 24'h00C000);  // row 63, col 63 -> code 3
      cfg_write(2'd2, 9'd0, 24'h000001);    // row 0, col 0 -> code 1
      pixel_check("R5 word/bit select", 8'h12, 12'd113, 12'd53, 24'h002200);
      pixel_check("R6 code1 corner R4", 8'h12, 12'd100, 12'd50, 24'h110000);
      pixel_check("R4 far corner code3", 8'h12, 12'd163, 12'd113, 24'h000033);
      pixel_check("R4 right edge out", 8'h12, 12'd164, 12'd113, 24'hA1B2C3);
      pixel_check("R4 bottom edge out", 8'h12, 12'd163, 12'd114, 24'hA1B2C3);
      pixel_check("R4 left edge out", 8'h12, 12'd99, 12'd50, 24'hA1B2C3);
      pixel_check("R6 code0 transparent", 8'h12, 12'd101, 12'd50, 24'hA1B2C3);
   endtask

   task automatic t_wrap();
      cfg_write(2'd3, 9'd0, {12'd4090, 12'd4090});
      pixel_check("R4 no wrap x", 8'h12, 12'd0, 12'd4090, 24'hA1B2C3);
      pixel_check("R4 at pos", 8'h12, 12'd4090, 12'd4090, 24'h110000);
      cfg_write(2'd3, 9'd0, {12'd100, 12'd50});
   endtask

   task automatic t_disable();
      cfg_write(2'd3, 9'd1, 24'h800000);
      pixel_check("R7 cursor hidden", 8'h12, 12'd100, 12'd50, 24'hA1B2C3);
      cfg_write(2'd3, 9'd1, 24'h000000);
      pixel_check("R7 cursor back", 8'h12, 12'd100, 12'd50, 24'h110000);
   endtask

   task automatic t_blank();
      cfg_write(2'd3, 9'd1, 24'h000400);
      pixel_check("R8 blank in cursor", 8'h12, 12'd100, 12'd50, 24'h000000);
      pixel_check("R8 blank outside", 8'hFF, 12'd900, 12'd900, 24'h000000);
      cfg_write(2'd3, 9'd1, 24'h800400);
      pixel_check("R8 blank with cursor off", 8'h12, 12'd900, 12'd900, 24'h000000);
      cfg_write(2'd3, 9'd1, 24'h000000);
      pixel_check("R8 unblank", 8'hFF, 12'd900, 12'd900, 24'h010203);
   endtask

   task automatic t_write_timing();
      @(negedge clk);
      cfg_we = 1'b1; cfg_target = 2'd0; cfg_addr = 9'h040; cfg_wdata = 24'h555555;
      drive_pix(8'h40, 12'd900, 12'd900, 1'b0, 1'b0);
      @(negedge clk);
      cfg_we = 1'b0;
      drive_pix(8'h40, 12'd901, 12'd900, 1'b0, 1'b0);
      @(negedge clk);
      idle_pix();
      check("R9 same-cycle pixel old", {8'd0, out_rgb}, 32'h000000);
      @(negedge clk);
      check("R9 next pixel new", {8'd0, out_rgb}, 32'h555555);
   endtask

   task automatic t_ignored();
      cfg_write(2'd1, 9'd3, 24'hFFFFFF);
      cfg_write(2'd1, 9'd4, 24'hFFFFFF);
      pixel_check("R10 cursor colour kept", 8'h12, 12'd100, 12'd50, 24'h110000);
      cfg_write(2'd0, 9'h112, 24'hABCDEF);
      pixel_check("R10 colour entry kept", 8'h12, 12'd900, 12'd900, 24'hA1B2C3);
      cfg_write(2'd3, 9'd2, 24'h000400);
      cfg_write(2'd3, 9'd5, 24'hFFFFFF);
      pixel_check("R10 control kept", 8'h12, 12'd100, 12'd50, 24'h110000);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lookup();
      t_stream();
      t_cursor();
      t_wrap();
      t_disable();
      t_blank();
      t_write_timing();
      t_ignored();
      done = 1'b1;
      report();
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R3 watchdog: actual=hung expected=finished");
         report();
      end
   end
endmodule